// File: doc/BRIEF.md
# Program/Erase Operation Sequencer

This block is the control half of a flash program/erase engine, as a bus master sees it. It takes single-cycle command strobes that a command decoder has already produced (program, erase, protect one block, unprotect all blocks, suspend, resume), together with a block address, a program-enable level, a high-voltage unlock level and a hardware reset level. It runs each accepted operation for a fixed number of clock cycles and reports activity on an open-drain style busy output and an 8-bit status word. The cell array itself is not modelled.

The controller is a state machine with eight named states. IDLE accepts new operations. PROG, ERASE and LOCK run a program, an erase and a protect/unprotect. ESUSP holds a suspended erase. During ESUSP a program to another block runs in PROG_ES and then returns to ESUSP. PSUSP holds a suspended program. ABORT holds busy for a bounded time after a hardware reset has cut an operation short.

The transitions are as follows. From IDLE an accepted command goes to PROG, ERASE or LOCK. Each of these returns to IDLE when its count expires. A suspend moves PROG to PSUSP and ERASE to ESUSP. A resume moves them back. A program in ESUSP moves to PROG_ES, and the end of its count moves back to ESUSP. A hardware reset moves any busy state to ABORT and any suspended state to IDLE. ABORT moves to IDLE when its count expires. A per-block protect bit array is held inside the block. All of its bits are set at power-up reset.

Top module: `pe_engine`

## Requirements
- R1: After power-up reset, status reads 0x80 and busy_pull is 0. An accepted program, erase or protect/unprotect drives busy_pull to 1 for exactly PROG_CYC, ERASE_CYC or LOCK_CYC cycles, starting with the cycle after the command is sampled. Status bit 7 (ready) is always the inverse of busy_pull.
- R2: While an operation runs, program, erase, protect and unprotect strobes are ignored. The run length is unchanged and no error bit is set. Suspend is the only command honoured.
- R3: When prog_en is 0, any of the four operation commands sets status bit 3 and starts nothing.
- R4: While hw_reset is 1, status bits 4 and 3 are cleared.
- R5: If hw_reset is 1 during a busy state, the operation is abandoned and busy_pull stays 1 for exactly ABORT_CYC cycles. It then falls even if hw_reset is still 1. An aborted protect leaves the protect bits unchanged.
- R6: A hw_reset while idle or suspended never sets busy_pull. It discards a suspended operation, which clears status bits 6 and 2, and a later resume does nothing.
- R7: At power-up every block is protected. A program or erase to a protected block sets status bit 4 (rejected) and does not start.
- R8: While hv_unlock is 1, protected blocks can be programmed and erased. Once hv_unlock returns to 0, those blocks are rejected again.
- R9: A completed protect sets the protect bit of the addressed block. A completed unprotect clears every protect bit.
- R10: A suspend during ERASE releases busy and sets status bit 6. A program to a different block is then accepted and runs PROG_CYC cycles. A program to the suspended block is rejected with bit 4. A resume completes the remaining ERASE_CYC count.
- R11: A suspend during PROG releases busy and sets status bit 2. Only resume is then honoured, and the program finishes its remaining PROG_CYC count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low |
| hw_reset | input | 1 | Hardware reset level, active high |
| prog_en | input | 1 | Program/erase enable level |
| hv_unlock | input | 1 | Temporary override of block protection |
| cmd_prog | input | 1 | Program strobe |
| cmd_erase | input | 1 | Block erase strobe |
| cmd_protect | input | 1 | Protect-block strobe |
| cmd_unprotect | input | 1 | Unprotect-all strobe |
| cmd_suspend | input | 1 | Suspend strobe |
| cmd_resume | input | 1 | Resume strobe |
| blk_addr | input | BW | Target block |
| busy_pull | output | 1 | 1 = pulling the busy line low |
| status | output | 8 | Bit 7 ready, bit 6 erase suspended, bit 4 rejected, bit 3 enable low, bit 2 program suspended, other bits 0 |

## Verification
A wrong state or a corrupted counter shows up first on busy_pull: the busy interval becomes longer or shorter than the cycle count the bench predicts. A wrong state can also appear as a busy level while the block should be suspended or idle. Each of these is visible within one cycle of the event. The bench therefore measures every busy interval to the exact cycle, including intervals split by suspend and resume. A lost suspended count shows up at the resume as a remaining time different from the initial count minus the elapsed cycles. Protect-bit errors show up only through acceptance or rejection of a later command, and the bench probes for them straight after each protect, unprotect and abort.

// File: rtl/pe_pkg.sv
package pe_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_PROG, S_ERASE, S_LOCK,
        S_ESUSP, S_PSUSP, S_PROG_ES, S_ABORT
    } pe_state_t;

    localparam int SB_READY  = 7;
    localparam int SB_ESUSP  = 6;
    localparam int SB_REJECT = 4;
    localparam int SB_ENLOW  = 3;
    localparam int SB_PSUSP  = 2;

    localparam int T_PRG  = 0;
    localparam int T_ERS  = 1;
    localparam int T_ABT  = 2;
    localparam int NTIMER = 3;
endpackage

// File: rtl/pe_timer.sv
module pe_timer #(
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          run,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (run && cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = run && (cnt == CW'(1));

    // R1
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !load) |=> !done);
endmodule

// File: rtl/pe_guard.sv
module pe_guard #(
    parameter int NBLK = 8,
    parameter int BW   = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [BW-1:0] blk,
    input  logic          hv_unlock,
    input  logic          set_one,
    input  logic [BW-1:0] set_blk,
    input  logic          clr_all,
    output logic          locked
);
    logic [NBLK-1:0] prot;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            prot <= '1;
        else if (clr_all)
            prot <= '0;
        else if (set_one)
            prot[set_blk] <= 1'b1;
    end

    assign locked = prot[blk] && !hv_unlock;

    // R8
    prot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_one && !clr_all) |=> $stable(prot));
endmodule

// File: rtl/pe_status.sv
module pe_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       set_rej,
    input  logic       set_enlow,
    input  logic       ready,
    input  logic       esusp,
    input  logic       psusp,
    output logic [7:0] stat
);
    logic rej_q, enlow_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rej_q   <= 1'b0;
            enlow_q <= 1'b0;
        end else if (clr) begin
            rej_q   <= 1'b0;
            enlow_q <= 1'b0;
        end else begin
            if (set_rej)   rej_q   <= 1'b1;
            if (set_enlow) enlow_q <= 1'b1;
        end
    end

    always_comb begin
        stat            = '0;
        stat[7]         = ready;
        stat[6]         = esusp;
        stat[4]         = rej_q;
        stat[3]         = enlow_q;
        stat[2]         = psusp;
    end

    // R4
    clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (stat[4] == 1'b0 && stat[3] == 1'b0));
    // R3
    enlow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[3] && !clr) |=> stat[3]);
endmodule

// File: rtl/pe_engine.sv
module pe_engine
    import pe_pkg::*;
#(
    parameter int NBLK      = 8,
    parameter int PROG_CYC  = 6,
    parameter int ERASE_CYC = 20,
    parameter int LOCK_CYC  = 4,
    parameter int ABORT_CYC = 5,
    localparam int BW       = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hw_reset,
    input  logic          prog_en,
    input  logic          hv_unlock,
    input  logic          cmd_prog,
    input  logic          cmd_erase,
    input  logic          cmd_protect,
    input  logic          cmd_unprotect,
    input  logic          cmd_suspend,
    input  logic          cmd_resume,
    input  logic [BW-1:0] blk_addr,
    output logic          busy_pull,
    output logic [7:0]    status
);
    localparam int M1   = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int M2   = (LOCK_CYC > ABORT_CYC) ? LOCK_CYC : ABORT_CYC;
    localparam int MAXC = (M1 > M2) ? M1 : M2;
    localparam int CW   = $clog2(MAXC + 1);

    pe_state_t state, nstate;
    logic [BW-1:0] op_blk;
    logic          lock_set;
    logic          cap_blk, lock_apply;
    logic          set_rej, set_enlow;
    logic          blk_locked, any_op, ers_sel_lock;
    logic [NTIMER-1:0] t_load, t_run, t_done;
    logic [CW-1:0]     t_val [NTIMER];

    assign any_op       = cmd_prog | cmd_erase | cmd_protect | cmd_unprotect;
    assign ers_sel_lock = !(cmd_erase && !cmd_prog);

    assign t_val[T_PRG] = CW'(PROG_CYC);
    assign t_val[T_ERS] = ers_sel_lock ? CW'(LOCK_CYC) : CW'(ERASE_CYC);
    assign t_val[T_ABT] = CW'(ABORT_CYC);

    assign t_run[T_PRG] = (state == S_PROG) || (state == S_PROG_ES);
    assign t_run[T_ERS] = (state == S_ERASE) || (state == S_LOCK);
    assign t_run[T_ABT] = (state == S_ABORT);

    genvar g;
    generate
        for (g = 0; g < NTIMER; g++) begin : g_tmr
            pe_timer #(.CW(CW)) u_tmr (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (t_load[g]),
                .load_val (t_val[g]),
                .run      (t_run[g]),
                .done     (t_done[g])
            );
        end
    endgenerate

    pe_guard #(.NBLK(NBLK), .BW(BW)) u_guard (
        .clk       (clk),
        .rst_n     (rst_n),
        .blk       (blk_addr),
        .hv_unlock (hv_unlock),
        .set_one   (lock_apply && lock_set),
        .set_blk   (op_blk),
        .clr_all   (lock_apply && !lock_set),
        .locked    (blk_locked)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            op_blk   <= '0;
            lock_set <= 1'b0;
        end else begin
            state <= nstate;
            if (cap_blk) begin
                op_blk   <= blk_addr;
                lock_set <= cmd_protect;
            end
        end
    end

    // next state and strobes
    always_comb begin
        nstate     = state;
        t_load     = '0;
        cap_blk    = 1'b0;
        lock_apply = 1'b0;
        set_rej    = 1'b0;
        set_enlow  = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (!hw_reset && any_op) begin
                    if (!prog_en) begin
                        set_enlow = 1'b1;
                    end else if (cmd_prog) begin
                        if (blk_locked) set_rej = 1'b1;
                        else begin
                            nstate        = S_PROG;
                            t_load[T_PRG] = 1'b1;
                            cap_blk       = 1'b1;
                        end
                    end else if (cmd_erase) begin
                        if (blk_locked) set_rej = 1'b1;
                        else begin
                            nstate        = S_ERASE;
                            t_load[T_ERS] = 1'b1;
                            cap_blk       = 1'b1;
                        end
                    end else begin
                        nstate        = S_LOCK;
                        t_load[T_ERS] = 1'b1;
                        cap_blk       = 1'b1;
                    end
                end
            end
            S_PROG: begin
                if (hw_reset) begin
                    nstate = S_ABORT; t_load[T_ABT] = 1'b1;
                end else if (t_done[T_PRG]) nstate = S_IDLE;
                else if (cmd_suspend)       nstate = S_PSUSP;
            end
            S_ERASE: begin
                if (hw_reset) begin
                    nstate = S_ABORT; t_load[T_ABT] = 1'b1;
                end else if (t_done[T_ERS]) nstate = S_IDLE;
                else if (cmd_suspend)       nstate = S_ESUSP;
            end
            S_LOCK: begin
                if (hw_reset) begin
                    nstate = S_ABORT; t_load[T_ABT] = 1'b1;
                end else if (t_done[T_ERS]) begin
                    nstate     = S_IDLE;
                    lock_apply = 1'b1;
                end
            end
            S_PROG_ES: begin
                if (hw_reset) begin
                    nstate = S_ABORT; t_load[T_ABT] = 1'b1;
                end else if (t_done[T_PRG]) nstate = S_ESUSP;
            end
            S_ESUSP: begin
                if (hw_reset) nstate = S_IDLE;
                else if (cmd_resume) nstate = S_ERASE;
                else if (cmd_prog) begin
                    if (!prog_en) set_enlow = 1'b1;
                    else if (blk_locked || blk_addr == op_blk) set_rej = 1'b1;
                    else begin
                        nstate        = S_PROG_ES;
                        t_load[T_PRG] = 1'b1;
                    end
                end
            end
            S_PSUSP: begin
                if (hw_reset) nstate = S_IDLE;
                else if (cmd_resume) nstate = S_PROG;
            end
            S_ABORT: begin
                if (t_done[T_ABT]) nstate = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        busy_pull = (state == S_PROG) || (state == S_ERASE) || (state == S_LOCK) ||
                    (state == S_PROG_ES) || (state == S_ABORT);
    end

    pe_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (hw_reset),
        .set_rej   (set_rej),
        .set_enlow (set_enlow),
        .ready     (!busy_pull),
        .esusp     ((state == S_ESUSP) || (state == S_PROG_ES)),
        .psusp     (state == S_PSUSP),
        .stat      (status)
    );

    // R6
    idle_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == S_IDLE || state == S_ESUSP || state == S_PSUSP) && hw_reset) |=> !busy_pull);
    // R5
    abort_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_pull && hw_reset && state != S_ABORT) |=> (state == S_ABORT && busy_pull));
    // R2
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_pull && !hw_reset && any_op) |=> $stable(status[4:3]));
    // R3
    enlow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !hw_reset && any_op && !prog_en) |=> (!busy_pull && status[3]));
    // R11
    psusp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PSUSP && !hw_reset && !cmd_resume) |=> (state == S_PSUSP && !busy_pull));
endmodule

// File: tb/sim_pe_engine.sv
module sim_pe_engine;
    localparam int NBLK = 8;
    localparam int PC = 6, EC = 20, LC = 4, AC = 5;
    localparam int BW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hw_reset = 1'b0, prog_en = 1'b1, hv_unlock = 1'b0;
    logic cmd_prog = 1'b0, cmd_erase = 1'b0, cmd_protect = 1'b0, cmd_unprotect = 1'b0;
    logic cmd_suspend = 1'b0, cmd_resume = 1'b0;
    logic [BW-1:0] blk_addr = '0;
    logic busy_pull;
    logic [7:0] status;

    int checks = 0, failures = 0;
    bit done_flag = 0;

    always #4 clk = ~clk;

    pe_engine #(.NBLK(NBLK), .PROG_CYC(PC), .ERASE_CYC(EC), .LOCK_CYC(LC), .ABORT_CYC(AC)) u0 (
        .clk(clk), .rst_n(rst_n), .hw_reset(hw_reset), .prog_en(prog_en),
        .hv_unlock(hv_unlock), .cmd_prog(cmd_prog), .cmd_erase(cmd_erase),
        .cmd_protect(cmd_protect), .cmd_unprotect(cmd_unprotect),
        .cmd_suspend(cmd_suspend), .cmd_resume(cmd_resume),
        .blk_addr(blk_addr), .busy_pull(busy_pull), .status(status)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // 0 prog 1 erase 2 protect 3 unprotect 4 suspend 5 resume
    task automatic pulse(input int which, input int blk);
        blk_addr = BW'(blk);
        case (which)
            0: cmd_prog = 1'b1;
            1: cmd_erase = 1'b1;
            2: cmd_protect = 1'b1;
            3: cmd_unprotect = 1'b1;
            4: cmd_suspend = 1'b1;
            default: cmd_resume = 1'b1;
        endcase
        @(negedge clk);
        cmd_prog = 0; cmd_erase = 0; cmd_protect = 0;
        cmd_unprotect = 0; cmd_suspend = 0; cmd_resume = 0;
    endtask

    task automatic count_busy(output int n);
        n = 0;
        while (busy_pull === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic hw_pulse(input string req);
        hw_reset = 1'b1;
        @(negedge clk);
        chk(req, busy_pull, 0);
        hw_reset = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_powerup();
        chk("R1 reset status", status, 8'h80);
        chk("R1 reset busy", busy_pull, 0);
    endtask

    task automatic t_protected();
        pulse(0, 2);
        chk("R7 prog protected busy", busy_pull, 0);
        chk("R7 prog protected status", status, 8'h90);
        pulse(1, 7);
        chk("R7 erase protected busy", busy_pull, 0);
        hw_pulse("R6 idle reset busy");
        chk("R4 status cleared", status, 8'h80);
    endtask

    task automatic t_hv();
        int n;
        hv_unlock = 1'b1;
        pulse(0, 2);
        count_busy(n);
        chk("R8 hv program length", n, PC);
        chk("R8 hv status", status, 8'h80);
        hv_unlock = 1'b0;
        pulse(0, 2);
        chk("R8 bit kept busy", busy_pull, 0);
        chk("R8 bit kept status", status, 8'h90);
        hw_pulse("R6 idle reset busy");
    endtask

    task automatic t_unprotect();
        int n;
        pulse(3, 0);
        count_busy(n);
        chk("R9 unprotect length", n, LC);
        pulse(0, 2);
        count_busy(n);
        chk("R9 R1 program after unprotect", n, PC);
        chk("R1 status after program", status, 8'h80);
    endtask

    task automatic t_enlow();
        prog_en = 1'b0;
        pulse(1, 0);
        chk("R3 enable low busy", busy_pull, 0);
        chk("R3 enable low status", status, 8'h88);
        prog_en = 1'b1;
        hw_pulse("R6 idle reset busy");
        chk("R4 enable bit cleared", status, 8'h80);
    endtask

    task automatic t_ignore();
        int n;
        pulse(1, 0);
        repeat (2) @(negedge clk);
        pulse(0, 1);
        pulse(1, 0);
        pulse(2, 3);
        count_busy(n);
        chk("R2 erase remainder", n, EC - 5);
        chk("R2 no error bits", status, 8'h80);
    endtask

    task automatic t_protect_one();
        int n;
        pulse(2, 5);
        count_busy(n);
        chk("R9 protect length", n, LC);
        pulse(0, 5);
        chk("R9 protected block rejected", status, 8'h90);
        hw_pulse("R6 idle reset busy");
        pulse(0, 4);
        count_busy(n);
        chk("R9 other block programmable", n, PC);
    endtask

    task automatic t_esusp();
        int n;
        pulse(1, 1);
        repeat (4) @(negedge clk);
        pulse(4, 0);
        chk("R10 suspend releases busy", busy_pull, 0);
        chk("R10 suspend status", status, 8'hC0);
        pulse(0, 1);
        chk("R10 same block rejected busy", busy_pull, 0);
        chk("R10 same block rejected status", status, 8'hD0);
        pulse(0, 3);
        count_busy(n);
        chk("R10 program in suspend length", n, PC);
        chk("R10 back to suspend", status, 8'hD0);
        pulse(5, 0);
        count_busy(n);
        chk("R10 erase remainder after resume", n, EC - 5);
        chk("R10 status after erase", status, 8'h90);
        hw_pulse("R6 idle reset busy");
    endtask

    task automatic t_psusp();
        int n;
        pulse(0, 3);
        @(negedge clk);
        pulse(4, 0);
        chk("R11 suspend releases busy", busy_pull, 0);
        chk("R11 suspend status", status, 8'h84);
        pulse(1, 0);
        chk("R11 erase ignored busy", busy_pull, 0);
        chk("R11 erase ignored status", status, 8'h84);
        pulse(5, 0);
        count_busy(n);
        chk("R11 program remainder", n, PC - 2);
    endtask

    task automatic t_abort();
        int n;
        pulse(1, 0);
        repeat (2) @(negedge clk);
        hw_reset = 1'b1;
        @(negedge clk);
        count_busy(n);
        chk("R5 abort length", n, AC);
        chk("R5 released under reset", busy_pull, 0);
        chk("R5 status under reset", status, 8'h80);
        hw_reset = 1'b0;
        @(negedge clk);
        pulse(2, 6);
        hw_reset = 1'b1;
        @(negedge clk);
        count_busy(n);
        chk("R5 protect abort length", n, AC);
        hw_reset = 1'b0;
        @(negedge clk);
        pulse(0, 6);
        count_busy(n);
        chk("R5 aborted protect left block open", n, PC);
    endtask

    task automatic t_susp_reset();
        pulse(1, 0);
        pulse(4, 0);
        chk("R6 suspended before reset", status, 8'hC0);
        hw_pulse("R6 reset in suspend busy");
        chk("R6 suspend discarded", status, 8'h80);
        pulse(5, 0);
        chk("R6 resume after discard", busy_pull, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_powerup();
        t_protected();
        t_hv();
        t_unprotect();
        t_enlow();
        t_ignore();
        t_protect_one();
        t_esusp();
        t_psusp();
        t_abort();
        t_susp_reset();
        if (!done_flag) begin
            done_flag = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        end
        $finish;
    end
endmodule